// File: doc/BRIEF.md
# Byte-Granular Soft Write-Lock Unit

This block sits on a peripheral bus in front of a bank of memory-mapped registers. It can block writes to single bytes of that bank. Every protected byte has its own soft lock bit. The lock bits are packed four to a lock register, and each one has a companion enable bit in the same register.

A single bus write can set or clear any subset of the lock bits. Only bits whose enable is set in that write change, so software never needs a read-modify-write. The enable bits are not stored.

Writes to the protected bank go out with per-byte strobes. The strobe of each locked byte is removed, and the unlocked bytes of the same word are still written. Reads are never blocked. The block also holds one configuration word, which only supervisor-mode writes may change.

Top module: `lock_unit`

## Requirements
- R1: After reset every lock bit and the configuration word are 0, so every protected byte is writable, and a read of any lock register or of the configuration word returns 0.
- R2: A write to lock register n updates lock bit k from wdata[k] only when enable bit wdata[4+k] is 1. When wdata[4+k] is 0, lock bit k keeps its value.
- R3: Lock register n, bit k guards byte lane k of protected word n, which is byte 4n+k. Lock register n sits at byte address LOCK_BASE+4n, and protected word n sits at PROT_BASE+4n.
- R4: A write to a protected word drives prot_we_o, prot_word_o and prot_wdata_o in the same cycle. prot_be_o equals bus_be_i with every locked lane cleared.
- R5: If no lane is left after the lock gating, prot_we_o stays low and prot_be_o is 0.
- R6: A read of a lock register returns the lock bits in rdata[3:0] and 0 in all other bits. The enable bits read as 0.
- R7: A read of a protected word drives prot_re_o and prot_word_o and returns prot_rdata_i on bus_rdata_o in the same cycle, whatever the lock state.
- R8: The configuration word is at GCR_OFFSET (0x3FFC) and can be read in either mode. A supervisor write updates the bytes selected by bus_be_i.
- R9: A user-mode write to the configuration word is ignored, and the word keeps its value.
- R10: Writes to lock registers, to the configuration word or to unmapped addresses never assert prot_we_o. A read of an unmapped address returns 0.
- R11: A write to a lock register with bus_be_i[0] = 0 leaves all lock bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_sup_i | input | 1 | Supervisor mode |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte strobes |
| bus_rdata_o | output | 32 | Read data, 0 when the access is not a read |
| prot_we_o | output | 1 | Write to protected bank |
| prot_re_o | output | 1 | Read from protected bank |
| prot_word_o | output | IDX_W | Protected word index |
| prot_be_o | output | 4 | Byte strobes after lock gating |
| prot_wdata_o | output | 32 | Write data to protected bank |
| prot_rdata_i | input | 32 | Read data from protected bank |

## Verification
The gating is tried with these strobe patterns:
- Full-word writes to a partly locked word, which show that locked and open lanes in one word are told apart.
- Sparse strobes that touch only open lanes, or only locked lanes, which separate a partial write from a fully suppressed one.
- Writes to a word whose neighbour is locked, which confirm that lock state does not leak across words.

Lock-register writes use enable masks that cover all, some or none of the lock bits, so that enable-qualified updates can be told apart from plain overwrites. Configuration writes are issued in both modes with partial strobes.

// File: rtl/lock_unit_pkg.sv
package lock_unit_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REGION_NONE,
    REGION_PROT,
    REGION_LOCK,
    REGION_CFG
  } region_e;
endpackage

// File: rtl/lock_unit_decode.sv
module lock_unit_decode
  import lock_unit_pkg::*;
#(
  parameter int NUM_BYTES  = 32,
  parameter int ADDR_W     = 14,
  parameter int PROT_BASE  = 'h0000,
  parameter int LOCK_BASE  = 'h2000,
  parameter int GCR_OFFSET = 'h3FFC,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] P_BASE = ADDR_W'(PROT_BASE);
  localparam logic [ADDR_W-1:0] L_BASE = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_BYTES);
  localparam logic [ADDR_W-1:0] CFG    = ADDR_W'(GCR_OFFSET);

  logic [ADDR_W-1:0] p_off, l_off;

  always_comb begin
    p_off    = addr_i - P_BASE;
    l_off    = addr_i - L_BASE;
    region_o = REGION_NONE;
    idx_o    = '0;
    if ((addr_i >> 2) == (CFG >> 2)) begin
      region_o = REGION_CFG;
    end else if (p_off < SPAN) begin
      region_o = REGION_PROT;
      idx_o    = IDX_W'(p_off >> 2);
    end else if (l_off < SPAN) begin
      region_o = REGION_LOCK;
      idx_o    = IDX_W'(l_off >> 2);
    end
  end
endmodule

// File: rtl/lock_unit_bank.sv
module lock_unit_bank
  import lock_unit_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [2*LANES-1:0]              wr_byte_i,
  output logic [NUM_WORDS-1:0][LANES-1:0] lock_o
);
  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_reg
    logic [LANES-1:0] q;
    logic             hit;
    logic [LANES-1:0] en, val;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(n));
    assign en  = wr_byte_i[2*LANES-1:LANES];
    assign val = wr_byte_i[LANES-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= (q & ~en) | (val & en);
    end

    assign lock_o[n] = q;
  end
endmodule

// File: rtl/lock_unit_gate.sv
module lock_unit_gate
  import lock_unit_pkg::*;
(
  input  logic             req_i,
  input  logic [LANES-1:0] be_i,
  input  logic [LANES-1:0] lock_i,
  output logic             we_o,
  output logic [LANES-1:0] be_o
);
  logic [LANES-1:0] open_lanes;

  always_comb begin
    open_lanes = be_i & ~lock_i;
    we_o       = req_i && (open_lanes != '0);
    be_o       = we_o ? open_lanes : '0;
  end
endmodule

// File: rtl/lock_unit_cfg.sv
module lock_unit_cfg
  import lock_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= '0;
      else if (wr_en_i && be_i[b]) q <= wdata_i[8*b +: 8];
    end
    assign q_o[8*b +: 8] = q;
  end
endmodule

// File: rtl/lock_unit.sv
module lock_unit
  import lock_unit_pkg::*;
#(
  parameter int NUM_BYTES  = 32,
  parameter int ADDR_W     = 14,
  parameter int PROT_BASE  = 'h0000,
  parameter int LOCK_BASE  = 'h2000,
  parameter int GCR_OFFSET = 'h3FFC,
  localparam int NUM_WORDS = NUM_BYTES / LANES,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_sup_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [LANES-1:0]  bus_be_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              prot_we_o,
  output logic              prot_re_o,
  output logic [IDX_W-1:0]  prot_word_o,
  output logic [LANES-1:0]  prot_be_o,
  output logic [DATA_W-1:0] prot_wdata_o,
  input  logic [DATA_W-1:0] prot_rdata_i
);
  region_e                        region;
  logic [IDX_W-1:0]               idx;
  logic                           wr_req, rd_req, lock_wr, cfg_wr;
  logic [NUM_WORDS-1:0][LANES-1:0] lock_bits;
  logic [LANES-1:0]               lane_lock;
  logic [DATA_W-1:0]              gcr_val;

  lock_unit_decode #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .PROT_BASE (PROT_BASE),
    .LOCK_BASE (LOCK_BASE),
    .GCR_OFFSET(GCR_OFFSET),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr_i  (bus_addr_i),
    .region_o(region),
    .idx_o   (idx)
  );

  assign wr_req  = bus_valid_i && bus_write_i;
  assign rd_req  = bus_valid_i && !bus_write_i;
  // lock bits and enables share byte lane 0
  assign lock_wr = wr_req && (region == REGION_LOCK) && bus_be_i[0];
  assign cfg_wr  = wr_req && (region == REGION_CFG) && bus_sup_i;

  lock_unit_bank #(
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (lock_wr),
    .wr_idx_i (idx),
    .wr_byte_i(bus_wdata_i[2*LANES-1:0]),
    .lock_o   (lock_bits)
  );

  assign lane_lock = lock_bits[idx];

  lock_unit_gate u_gate (
    .req_i (wr_req && (region == REGION_PROT)),
    .be_i  (bus_be_i),
    .lock_i(lane_lock),
    .we_o  (prot_we_o),
    .be_o  (prot_be_o)
  );

  lock_unit_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(cfg_wr),
    .be_i   (bus_be_i),
    .wdata_i(bus_wdata_i),
    .q_o    (gcr_val)
  );

  assign prot_re_o    = rd_req && (region == REGION_PROT);
  assign prot_word_o  = idx;
  assign prot_wdata_o = bus_wdata_i;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_req) begin
      unique case (region)
        REGION_PROT: bus_rdata_o = prot_rdata_i;
        REGION_LOCK: bus_rdata_o = DATA_W'(lane_lock);
        REGION_CFG:  bus_rdata_o = gcr_val;
        default:     bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lock_unit_chk.sv
module lock_unit_chk
  import lock_unit_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int GCR_OFFSET = 'h3FFC,
  parameter int NUM_WORDS  = 8,
  parameter int IDX_W      = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            bus_valid_i,
  input logic                            bus_write_i,
  input logic                            bus_sup_i,
  input logic [ADDR_W-1:0]               bus_addr_i,
  input logic [LANES-1:0]                bus_be_i,
  input logic [DATA_W-1:0]               bus_rdata_o,
  input logic [DATA_W-1:0]               prot_rdata_i,
  input logic                            prot_we_o,
  input logic                            prot_re_o,
  input logic [LANES-1:0]                prot_be_o,
  input logic [IDX_W-1:0]                prot_word_o,
  input logic [NUM_WORDS-1:0][LANES-1:0] lock_i,
  input logic [DATA_W-1:0]               gcr_i
);
  localparam logic [ADDR_W-1:0] CFG = ADDR_W'(GCR_OFFSET);
  logic cfg_hit;
  assign cfg_hit = (bus_addr_i >> 2) == (CFG >> 2);

  assert_gate_subset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> ((prot_be_o & ~bus_be_i) == '0));

  assert_locked_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> ((prot_be_o & lock_i[prot_word_o]) == '0));

  assert_no_empty_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (prot_be_o != '0));

  assert_write_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (bus_valid_i && bus_write_i && !prot_re_o));

  assert_read_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_re_o |-> (bus_rdata_o == prot_rdata_i));

  assert_cfg_user_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && !bus_sup_i && cfg_hit) |=> $stable(gcr_i));

  assert_lock_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && bus_write_i) |=> $stable(lock_i));
endmodule

bind lock_unit lock_unit_chk #(
  .ADDR_W    (ADDR_W),
  .GCR_OFFSET(GCR_OFFSET),
  .NUM_WORDS (NUM_WORDS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_sup_i   (bus_sup_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_rdata_o (bus_rdata_o),
  .prot_rdata_i(prot_rdata_i),
  .prot_we_o   (prot_we_o),
  .prot_re_o   (prot_re_o),
  .prot_be_o   (prot_be_o),
  .prot_word_o (prot_word_o),
  .lock_i      (lock_bits),
  .gcr_i       (gcr_val)
);

// File: tb/tb_lock_unit.sv
module tb_lock_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0, bus_sup_i = 1'b0;
  logic [13:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_rdata_o;
  logic        prot_we_o, prot_re_o;
  logic [2:0]  prot_word_o;
  logic [3:0]  prot_be_o;
  logic [31:0] prot_wdata_o;
  logic [31:0] prot_rdata_i = 32'hC0DE_F00D;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  lock_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_sup_i(bus_sup_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_be_i(bus_be_i),
    .bus_rdata_o(bus_rdata_o), .prot_we_o(prot_we_o), .prot_re_o(prot_re_o),
    .prot_word_o(prot_word_o), .prot_be_o(prot_be_o), .prot_wdata_o(prot_wdata_o),
    .prot_rdata_i(prot_rdata_i)
  );

  typedef struct packed {
    logic        wr;
    logic        sup;
    logic [13:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] rdata;
    logic        pwe;
    logic        pre;
    logic [3:0]  pbe;
    logic [2:0]  word;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,14'h2000,32'h0,       4'h0,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd1},  // R1 lock0 reads 0
    '{1'b0,1'b0,14'h3FFC,32'h0,       4'h0,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd1},  // R1 cfg reads 0
    '{1'b1,1'b0,14'h0004,32'h11223344,4'hF,32'h0,        1'b1,1'b0,4'hF,3'd1,4'd4},  // R4 open write
    '{1'b1,1'b0,14'h2004,32'h00000035,4'h1,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd2},  // R2 enables 0,1
    '{1'b0,1'b0,14'h2004,32'h0,       4'h0,32'h1,        1'b0,1'b0,4'h0,3'd0,4'd6},  // R6 enables read 0
    '{1'b1,1'b0,14'h0004,32'hAABBCCDD,4'hF,32'h0,        1'b1,1'b0,4'hE,3'd1,4'd3},  // R3 lane 0 locked
    '{1'b1,1'b0,14'h0000,32'h55667788,4'hF,32'h0,        1'b1,1'b0,4'hF,3'd0,4'd3},  // R3 neighbour open
    '{1'b1,1'b1,14'h2004,32'h000000CC,4'h1,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd2},  // R2 enables 2,3
    '{1'b0,1'b0,14'h2004,32'h0,       4'h0,32'hD,        1'b0,1'b0,4'h0,3'd0,4'd2},  // R2 bit0 kept
    '{1'b1,1'b0,14'h0004,32'h01020304,4'h6,32'h0,        1'b1,1'b0,4'h2,3'd1,4'd4},  // R4 sparse
    '{1'b1,1'b0,14'h0004,32'h01020304,4'h1,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd5},  // R5 all gated
    '{1'b0,1'b0,14'h0004,32'h0,       4'h0,32'hC0DEF00D, 1'b0,1'b1,4'h0,3'd1,4'd7},  // R7 read locked word
    '{1'b1,1'b1,14'h2004,32'h000000F0,4'hE,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd11}, // R11 no lane 0
    '{1'b0,1'b0,14'h2004,32'h0,       4'h0,32'hD,        1'b0,1'b0,4'h0,3'd0,4'd11}, // R11 unchanged
    '{1'b1,1'b0,14'h3FFC,32'hDEADBEEF,4'hF,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd10}, // R10 cfg write
    '{1'b0,1'b0,14'h3FFC,32'h0,       4'h0,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd9},  // R9 user ignored
    '{1'b1,1'b1,14'h3FFC,32'h12345678,4'h3,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd8},  // R8 partial
    '{1'b0,1'b0,14'h3FFC,32'h0,       4'h0,32'h00005678, 1'b0,1'b0,4'h0,3'd0,4'd8},  // R8 user read
    '{1'b1,1'b0,14'h201C,32'h000000F8,4'h1,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd2},  // R2 lock7 = 1000
    '{1'b1,1'b0,14'h001C,32'hFFFFFFFF,4'hF,32'h0,        1'b1,1'b0,4'h7,3'd7,4'd3},  // R3 last word
    '{1'b0,1'b0,14'h1000,32'h0,       4'h0,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd10}, // R10 unmapped read
    '{1'b1,1'b1,14'h1000,32'hFFFFFFFF,4'hF,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd10}, // R10 unmapped write
    '{1'b1,1'b0,14'h2004,32'h000000F0,4'h1,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd2},  // R2 clear all
    '{1'b0,1'b0,14'h2004,32'h0,       4'h0,32'h0,        1'b0,1'b0,4'h0,3'd0,4'd2}   // R2 reads 0
  };

  task automatic drive(input logic wr, input logic sup, input logic [13:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = wr; bus_sup_i = sup;
    bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_be_i = '0;
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet in reset
    check("R1 reset outputs", {bus_rdata_o[3:0], prot_we_o, prot_re_o, prot_be_o},
          {4'h0, 1'b0, 1'b0, 4'h0});
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [2:0] aw;
      drive(v.wr, v.sup, v.addr, v.wdata, v.be);
      aw = (v.pwe || v.pre) ? prot_word_o : 3'd0;
      checks++;
      if ({bus_rdata_o, prot_we_o, prot_re_o, prot_be_o, aw} !==
          {v.rdata, v.pwe, v.pre, v.pbe, v.word}) begin
        failures++;
        $display("FAIL R%0d vec %0d actual=%h/%b/%b/%h/%0d expected=%h/%b/%b/%h/%0d",
                 v.req, i, bus_rdata_o, prot_we_o, prot_re_o, prot_be_o, aw,
                 v.rdata, v.pwe, v.pre, v.pbe, v.word);
      end
    end

    // R4: write data passed unchanged
    drive(1'b1, 1'b0, 14'h0008, 32'hCAFE_1234, 4'hF);
    check("R4 wdata", prot_wdata_o, 32'hCAFE_1234);

    // R2: lock all of reg 3, then reset restores R1 state
    drive(1'b1, 1'b1, 14'h200C, 32'h0000_00FF, 4'h1);
    drive(1'b0, 1'b0, 14'h200C, 32'h0, 4'h0);
    check("R2 lock3 all set", bus_rdata_o, 32'hF);
    drive(1'b1, 1'b0, 14'h000C, 32'h0, 4'hF);
    check("R5 word3 blocked", {31'd0, prot_we_o}, 32'd0);
    drive(1'b1, 1'b1, 14'h3FFC, 32'hFFFF_FFFF, 4'hF);
    idle();
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 14'h200C, 32'h0, 4'h0);
    check("R1 lock3 after reset", bus_rdata_o, 32'h0);
    drive(1'b0, 1'b1, 14'h3FFC, 32'h0, 4'h0);
    check("R1 cfg after reset", bus_rdata_o, 32'h0);
    drive(1'b1, 1'b0, 14'h000C, 32'h0, 4'hF);
    check("R1 word3 writable", {27'd0, prot_we_o, prot_be_o}, {27'd0, 1'b1, 4'hF});
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule